// File: doc/BRIEF.md
# Host Port to DSP Local Bus Bridge

This block connects a backplane slave port to the memory of a signal processor that normally owns a shared local bus. An upstream decoder has already checked the address and the modifier. It raises `vmeValid` for as long as the access lasts. The bridge then asks the processor for its bus with a request/grant handshake. When the grant arrives, it turns the backplane byte address into the processor's word index and runs a local cycle of fixed length. It then gives the bus back and acknowledges the host.

On the processor side every object takes one address step. In 32-bit transfers the word index is therefore the byte address shifted down by two. In 16-bit transfers the same word index is used, and address bit 1 picks the half of the word. The low half is at the even 16-bit location and the high half at the odd one. Byte lanes on the local bus carry the half-word writes, so no read-modify-write cycle is needed.

A write-protect input blocks writes. If the processor never answers the request, a programmable timeout drops the request and returns a bus error in place of the acknowledge.

Top module: `host_dsp_bridge`

## Requirements
- R1: After reset, `busReq`, `vmeDtack`, `vmeBerr`, `locRd` and `locWr` are all low.
- R2: A valid access raises `busReq`. `locRd` and `locWr` are only ever high while both `busReq` and `busGrant` are high.
- R3: With `vmeLword`=1 (32-bit), `locAddr` equals the byte address shifted right by 2. `locBe` is 4'b1111. `locWdata` is the host write data. A read returns the full local word.
- R4: With `vmeLword`=0 (16-bit), `locAddr` also equals the byte address shifted right by 2. If address bit 1 is 0, `locBe` is 4'b0011 (bits 15:0); if it is 1, `locBe` is 4'b1100 (bits 31:16). Write data is placed in both halves. A read returns the selected half in bits 15:0, with bits 31:16 zero.
- R5: Once granted, the local strobe (`locRd` or `locWr`) stays high for exactly CYCLE_CLKS clocks (default 6).
- R6: `vmeDtack` rises only after `busReq` has fallen. It then stays high until `vmeValid` drops.
- R7: A write accepted while `wrProtect` is high never asserts `locWr`. Memory stays unchanged, and the access is still acknowledged.
- R8: If no grant arrives within GRANT_TIMEOUT clocks of raising `busReq`, the request is dropped and `vmeBerr` is raised instead of `vmeDtack`. No local strobe occurs. `busReq` is high for exactly GRANT_TIMEOUT clocks.
- R9: A completed access makes no new request while `vmeValid` stays high. A new access needs `vmeValid` to drop and rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vmeValid | input | 1 | Decoded access in progress (held until completion seen) |
| vmeWrite | input | 1 | 1 = write, 0 = read |
| vmeLword | input | 1 | 1 = 32-bit transfer, 0 = 16-bit transfer |
| vmeAddr | input | VME_AW-1 | Host byte address bits VME_AW-1 down to 1 |
| vmeWdata | input | 32 | Host write data (16-bit writes use bits 15:0) |
| wrProtect | input | 1 | Blocks writes when high |
| vmeRdata | output | 32 | Read data, valid with `vmeDtack` |
| vmeDtack | output | 1 | Data acknowledge |
| vmeBerr | output | 1 | Bus error on grant timeout |
| busReq | output | 1 | Local bus request to the processor |
| busGrant | input | 1 | Local bus grant from the processor |
| locAddr | output | VME_AW-2 | Processor word index |
| locBe | output | 4 | Local byte-lane enables |
| locWdata | output | 32 | Local write data |
| locRdata | input | 32 | Local read data |
| locRd | output | 1 | Local read strobe |
| locWr | output | 1 | Local write strobe |

## Verification
Random 32-bit and 16-bit reads and writes run over both halves of the mapped window. They use random grant delays and random write protection. Reads of words written earlier show whether the halves are in the right order and the shift amount is right for each width. The varied grant delays separate the cycle length, counted from the grant, from the request latency. Directed cases cover:
- a 32-bit write read back as two halves;
- a protected write followed by a read-back;
- a never-granted request, whose request length is measured against the timeout;
- an acknowledge held with the strobe kept high, which shows that no second request is made.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_CYC, ST_DONE, ST_ERR
  } brState_t;

  typedef struct packed {
    logic load;     // latch host address, data and width
    logic capture;  // latch local read data
  } dpStrobe_t;
endpackage

// File: rtl/bridge_datapath.sv
module bridge_datapath
  import bridge_pkg::*;
#(
  parameter int VME_AW = 24,
  parameter int DW     = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          ctl,
  input  logic [VME_AW-1:1]  vmeAddr,
  input  logic [DW-1:0]      vmeWdata,
  input  logic               vmeLword,
  input  logic [DW-1:0]      locRdata,
  output logic [VME_AW-3:0]  locAddr,
  output logic [DW/8-1:0]    locBe,
  output logic [DW-1:0]      locWdata,
  output logic [DW-1:0]      vmeRdata
);
  localparam int HALF_W = DW / 2;
  localparam int LANES  = DW / 8;
  localparam int HLANES = LANES / 2;

  logic [VME_AW-1:1] addrQ;
  logic [DW-1:0]     wdataQ;
  logic              lwordQ;
  logic [DW-1:0]     rdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      lwordQ <= 1'b0;
      rdataQ <= '0;
    end else begin
      if (ctl.load) begin
        addrQ  <= vmeAddr;
        wdataQ <= vmeWdata;
        lwordQ <= vmeLword;
      end
      if (ctl.capture) begin
        if (lwordQ)        rdataQ <= locRdata;
        else if (addrQ[1]) rdataQ <= {{HALF_W{1'b0}}, locRdata[DW-1:HALF_W]};
        else               rdataQ <= {{HALF_W{1'b0}}, locRdata[HALF_W-1:0]};
      end
    end
  end

  assign locAddr  = addrQ[VME_AW-1:2];
  assign locWdata = lwordQ ? wdataQ : {wdataQ[HALF_W-1:0], wdataQ[HALF_W-1:0]};
  assign vmeRdata = rdataQ;

  always_comb begin
    if (lwordQ)        locBe = '1;
    else if (addrQ[1]) locBe = {{HLANES{1'b1}}, {HLANES{1'b0}}};
    else               locBe = {{HLANES{1'b0}}, {HLANES{1'b1}}};
  end
endmodule

// File: rtl/bridge_control.sv
module bridge_control
  import bridge_pkg::*;
#(
  parameter int CYCLE_CLKS    = 6,
  parameter int GRANT_TIMEOUT = 250
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      vmeValid,
  input  logic      vmeWrite,
  input  logic      wrProtect,
  input  logic      busGrant,
  output dpStrobe_t ctl,
  output logic      busReq,
  output logic      vmeDtack,
  output logic      vmeBerr,
  output logic      locRd,
  output logic      locWr
);
  localparam int CW = $clog2(CYCLE_CLKS + 1);
  localparam int WW = $clog2(GRANT_TIMEOUT + 1);
  localparam logic [CW-1:0] CYC_LAST  = CW'(CYCLE_CLKS - 1);
  localparam logic [WW-1:0] WAIT_LAST = WW'(GRANT_TIMEOUT - 1);

  brState_t      state;
  logic [CW-1:0] cycCnt;
  logic [WW-1:0] waitCnt;
  logic          writeQ;
  logic          protQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cycCnt  <= '0;
      waitCnt <= '0;
      writeQ  <= 1'b0;
      protQ   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (vmeValid) begin
          state   <= ST_REQ;
          waitCnt <= '0;
          writeQ  <= vmeWrite;
          protQ   <= wrProtect;
        end
        ST_REQ: begin
          if (busGrant) begin
            state  <= ST_CYC;
            cycCnt <= '0;
          end else if (waitCnt == WAIT_LAST) begin
            state <= ST_ERR;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_CYC: begin
          if (cycCnt == CYC_LAST) state <= ST_DONE;
          else                    cycCnt <= cycCnt + 1'b1;
        end
        ST_DONE, ST_ERR: if (!vmeValid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load    = (state == ST_IDLE) && vmeValid;
    ctl.capture = (state == ST_CYC) && (cycCnt == CYC_LAST);
  end

  assign busReq   = (state == ST_REQ) || (state == ST_CYC);
  assign locRd    = (state == ST_CYC) && !writeQ;
  assign locWr    = (state == ST_CYC) && writeQ && !protQ;
  assign vmeDtack = (state == ST_DONE);
  assign vmeBerr  = (state == ST_ERR);
endmodule

// File: rtl/host_dsp_bridge.sv
module host_dsp_bridge
  import bridge_pkg::*;
#(
  parameter int VME_AW        = 24,
  parameter int CYCLE_CLKS    = 6,
  parameter int GRANT_TIMEOUT = 250
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vmeValid,
  input  logic              vmeWrite,
  input  logic              vmeLword,
  input  logic [VME_AW-1:1] vmeAddr,
  input  logic [31:0]       vmeWdata,
  input  logic              wrProtect,
  output logic [31:0]       vmeRdata,
  output logic              vmeDtack,
  output logic              vmeBerr,
  output logic              busReq,
  input  logic              busGrant,
  output logic [VME_AW-3:0] locAddr,
  output logic [3:0]        locBe,
  output logic [31:0]       locWdata,
  input  logic [31:0]       locRdata,
  output logic              locRd,
  output logic              locWr
);
  dpStrobe_t ctl;

  bridge_control #(.CYCLE_CLKS(CYCLE_CLKS), .GRANT_TIMEOUT(GRANT_TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .vmeValid(vmeValid), .vmeWrite(vmeWrite),
    .wrProtect(wrProtect), .busGrant(busGrant), .ctl(ctl), .busReq(busReq),
    .vmeDtack(vmeDtack), .vmeBerr(vmeBerr), .locRd(locRd), .locWr(locWr)
  );

  bridge_datapath #(.VME_AW(VME_AW), .DW(32)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .vmeAddr(vmeAddr), .vmeWdata(vmeWdata),
    .vmeLword(vmeLword), .locRdata(locRdata), .locAddr(locAddr), .locBe(locBe),
    .locWdata(locWdata), .vmeRdata(vmeRdata)
  );
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
  parameter int CYCLE_CLKS = 6
) (
  input logic clk,
  input logic rstN,
  input logic vmeValid,
  input logic wrProtect,
  input logic busReq,
  input logic busGrant,
  input logic vmeDtack,
  input logic vmeBerr,
  input logic locRd,
  input logic locWr
);
  logic        strobe;
  logic        prevStrobe;
  logic [15:0] runLen;

  assign strobe = locRd || locWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevStrobe <= 1'b0;
      runLen     <= '0;
    end else begin
      prevStrobe <= strobe;
      runLen     <= strobe ? runLen + 16'd1 : 16'd0;
    end
  end

  assert_strobe_needs_grant_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe |-> (busReq && busGrant));

  assert_strobe_length_R5: assert property (@(posedge clk) disable iff (!rstN)
    (prevStrobe && !strobe) |-> (runLen == 16'(CYCLE_CLKS)));

  assert_ack_after_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    vmeDtack |-> !busReq);

  assert_ack_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (vmeDtack && vmeValid) |=> vmeDtack);

  assert_protect_no_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    locWr |-> !wrProtect);

  assert_error_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    vmeBerr |-> (!vmeDtack && !busReq && !strobe));

  assert_no_rerequest_R9: assert property (@(posedge clk) disable iff (!rstN)
    (vmeDtack && vmeValid) |=> !busReq);
endmodule

bind host_dsp_bridge bridge_checker #(.CYCLE_CLKS(CYCLE_CLKS)) u_chk (.*);

// File: tb/host_dsp_bridge_bench.sv
module host_dsp_bridge_bench;
  localparam int VME_AW  = 24;
  localparam int CYC     = 6;
  localparam int TIMEOUT = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vmeValid = 1'b0, vmeWrite = 1'b0, vmeLword = 1'b0, wrProtect = 1'b0;
  logic [VME_AW-1:1] vmeAddr = '0;
  logic [31:0] vmeWdata = '0, vmeRdata, locWdata, locRdata;
  logic vmeDtack, vmeBerr, busReq, locRd, locWr;
  logic busGrant = 1'b0;
  logic [VME_AW-3:0] locAddr;
  logic [3:0] locBe;

  int checks = 0, errors = 0, cycles = 0;
  int grantDelay = 0, grantCnt = 0;
  logic [31:0] mem [256];
  logic [31:0] refMem [256];

  always #2 clk = ~clk;

  host_dsp_bridge #(.VME_AW(VME_AW), .CYCLE_CLKS(CYC), .GRANT_TIMEOUT(TIMEOUT)) u_host_dsp_bridge (
    .clk(clk), .rstN(rstN), .vmeValid(vmeValid), .vmeWrite(vmeWrite), .vmeLword(vmeLword),
    .vmeAddr(vmeAddr), .vmeWdata(vmeWdata), .wrProtect(wrProtect), .vmeRdata(vmeRdata),
    .vmeDtack(vmeDtack), .vmeBerr(vmeBerr), .busReq(busReq), .busGrant(busGrant),
    .locAddr(locAddr), .locBe(locBe), .locWdata(locWdata), .locRdata(locRdata),
    .locRd(locRd), .locWr(locWr)
  );

  // processor side: grant after grantDelay clocks (never if negative), memory with lanes
  always @(posedge clk) begin
    if (!busReq) begin
      busGrant <= 1'b0;
      grantCnt <= 0;
    end else if (grantDelay >= 0 && grantCnt >= grantDelay) begin
      busGrant <= 1'b1;
    end else begin
      grantCnt <= grantCnt + 1;
    end
    if (locWr)
      for (int b = 0; b < 4; b++)
        if (locBe[b]) mem[locAddr[7:0]][b*8 +: 8] <= locWdata[b*8 +: 8];
  end
  assign locRdata = mem[locAddr[7:0]];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] refRead(input logic lw, input logic [23:0] a);
    logic [31:0] w = refMem[a[9:2]];
    if (lw) return w;
    return a[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
  endfunction

  function automatic logic [3:0] refBe(input logic lw, input logic [23:0] a);
    if (lw) return 4'hF;
    return a[1] ? 4'hC : 4'h3;
  endfunction

  task automatic refWrite(input logic lw, input logic [23:0] a, input logic [31:0] d);
    if (lw) refMem[a[9:2]] = d;
    else if (a[1]) refMem[a[9:2]][31:16] = d[15:0];
    else refMem[a[9:2]][15:0] = d[15:0];
  endtask

  task automatic access(input logic wr, input logic lw, input logic [23:0] a,
                        input logic [31:0] d, input logic prot, input int gd);
    int strobeCnt = 0, wrCnt = 0, n = 0, reqCnt = 0;
    logic [VME_AW-3:0] seenAddr = '0;
    logic [3:0] seenBe = '0;
    logic [31:0] expRd;
    logic [31:0] expWd;
    expRd = refRead(lw, a);
    expWd = lw ? d : {d[15:0], d[15:0]};
    @(negedge clk);
    grantDelay = gd;
    vmeWrite = wr; vmeLword = lw; vmeAddr = a[23:1]; vmeWdata = d; wrProtect = prot;
    vmeValid = 1'b1;
    while (n < 1000) begin
      @(negedge clk);
      n++;
      if (busReq) reqCnt++;
      if (locRd || locWr) begin
        strobeCnt++;
        seenAddr = locAddr;
        seenBe = locBe;
        if (locWr) begin
          wrCnt++;
          check(locWdata == expWd, lw ? "R3 write data" : "R4 write data", locWdata, expWd);
        end
      end
      if (vmeDtack || vmeBerr) break;
    end
    if (gd < 0) begin
      check(vmeBerr && !vmeDtack, "R8 error instead of ack", {vmeBerr, vmeDtack}, 2'b10);
      check(reqCnt == TIMEOUT, "R8 request length", reqCnt, TIMEOUT);
      check(strobeCnt == 0, "R8 no local strobe", strobeCnt, 0);
    end else begin
      check(vmeDtack && !vmeBerr, "R6 ack", {vmeDtack, vmeBerr}, 2'b10);
      check(!busReq, "R6 request released at ack", busReq, 0);
      check(seenAddr == VME_AW'(a >> 2) || (wr && prot), lw ? "R3 word index" : "R4 word index",
            seenAddr, a >> 2);
      if (!(wr && prot))
        check(seenBe == refBe(lw, a), lw ? "R3 lanes" : "R4 lanes", seenBe, refBe(lw, a));
      if (wr && prot) begin
        check(wrCnt == 0 && strobeCnt == 0, "R7 no local write", wrCnt, 0);
      end else begin
        check(strobeCnt == CYC, "R5 strobe length", strobeCnt, CYC);
        if (wr) refWrite(lw, a, d);
        else check(vmeRdata == expRd, lw ? "R3 read data" : "R4 read data", vmeRdata, expRd);
      end
    end
    vmeValid = 1'b0;
    @(negedge clk);
    check(!vmeDtack && !vmeBerr, "R6 ack drops after strobe", {vmeDtack, vmeBerr}, 0);
  endtask

  initial begin
    logic [23:0] a;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 32'h9E37_0000 ^ (i * 32'h0101_0101);
      refMem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check(!busReq && !vmeDtack && !vmeBerr && !locRd && !locWr, "R1 reset state",
          {busReq, vmeDtack, vmeBerr, locRd, locWr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busReq && !vmeDtack && !vmeBerr, "R1 idle after reset", {busReq, vmeDtack, vmeBerr}, 0);

    // directed: 32-bit write then two 16-bit halves
    access(1, 1, 24'h090000, 32'h1234_5678, 0, 2);
    access(0, 0, 24'h090000, 0, 0, 0);
    access(0, 0, 24'h090002, 0, 0, 3);
    access(0, 1, 24'h08FFFC, 0, 0, 1);
    // directed: 16-bit write of upper half, read back full word
    access(1, 0, 24'h080006, 32'h0000_BEEF, 0, 0);
    access(0, 1, 24'h080004, 0, 0, 0);
    // directed: protected write then readback
    access(1, 1, 24'h080010, 32'hDEAD_0000, 1, 1);
    access(0, 1, 24'h080010, 0, 0, 1);
    // directed: timeout
    access(0, 1, 24'h080020, 0, 0, -1);
    access(0, 1, 24'h080020, 0, 0, 0);

    // directed R9: hold strobe after ack, no new request
    @(negedge clk);
    grantDelay = 0; vmeWrite = 0; vmeLword = 1; vmeAddr = 23'h040000; wrProtect = 0;
    vmeValid = 1'b1;
    for (int k = 0; k < 40 && !vmeDtack; k++) @(negedge clk);
    begin
      int reqSeen = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (busReq) reqSeen++;
      end
      check(reqSeen == 0, "R9 no request while strobe held", reqSeen, 0);
      check(vmeDtack, "R6 ack held while strobe held", vmeDtack, 1);
    end
    vmeValid = 1'b0;
    @(negedge clk);

    // random mix
    for (int i = 0; i < 60; i++) begin
      a = 24'h080000 + 24'(($urandom % 40) << 1);
      access(1'($urandom % 2), 1'($urandom % 2), (($urandom % 2) != 0) ? a : {a[23:2], 2'b00},
             $urandom, 1'(($urandom % 5) == 0), int'($urandom % 8));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule